// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block sits behind a CAN receiver front end. For each decoded frame it gets the identifier, a format flag (standard or extended), the length code, up to eight data bytes and a one-cycle valid strobe. It compares the frame against a bank of receive mailboxes. Each mailbox holds an enable bit, an acceptance mask and an acceptance identifier word.

The frame is stored in the lowest-numbered enabled mailbox that matches strictly. A strict match requires the mailbox to be idle, the format flags to be equal, and the identifier bits selected by the mask to agree. A standard-format mailbox therefore never takes an extended frame. A capture never changes the configured acceptance word, and it keeps all 29 extended identifier bits.

A captured mailbox holds the following:
- the received identifier word
- a family value, which is the received identifier ANDed with the mask
- two data words
- a status word with the timestamp, the length code and a ready flag

The mailbox then ignores new frames until software writes a transfer command. Frames that no mailbox accepts are dropped, and each drop increments a counter. A simple register port configures the mailboxes and reads them back.

Top module: `can_rx_mbox_filter`

## Requirements
- R1: After reset, the drop counter is 0. Every mailbox register reads 0, so all mailboxes are disabled and not ready.
- R2: A standard frame is stored as the identifier word {bit29=0, bits28:18 = id[10:0], bits17:0 = 0}. For example, 0x123 is stored as 0x048C0000.
- R3: An extended frame is stored with bit 29 set and id[28:0] in bits 28:0. For example, 0x1576 is stored as 0x20001576 and 0x15761234 as 0x35761234.
- R4: A match requires bit 29 of the frame word to equal bit 29 of the acceptance word, whatever the mask holds. A mailbox with mask 0 and acceptance word 0 accepts every standard frame and never an extended one.
- R5: A mailbox with mask 0x20000000 and acceptance word 0x20000000 accepts every extended frame and no standard frame.
- R6: A mailbox whose enable bit (mode register bit 0) is 0 never captures.
- R7: When several mailboxes match, only the lowest-numbered one captures.
- R8: Data byte 0 (frm_data[7:0]) lands in bits 7:0 of the low data word. Bytes 4 to 7 form the high data word.
- R9: The status word holds the following fields:

  | Bits | Contents |
  |------|----------|
  | 15:0 | Free-running timestamp, sampled at the capturing clock edge. The counter is 0 in the first cycle after reset and increments every cycle. |
  | 19:16 | Length code |
  | 23 | Ready flag |

- R10: A capture never alters a mailbox's mask, acceptance word or enable bit.
- R11: A ready mailbox ignores further frames. Writing the mode register with bit 8 set (the transfer command) clears the ready flag.
- R12: A frame that matches no mailbox is dropped, and drop_count increments by 1.
- R13: Identifier bits that are clear in the mask (bits 28:0) are ignored in the compare. The family register reads the received word bits 28:0 ANDed with the mask.

Register address: bits 5:3 select the mailbox. Bits 2:0 select the register, as listed below. Only registers 0 to 2 are writable.

| Address bits 2:0 | Register |
|------------------|----------|
| 0 | Mode |
| 1 | Mask |
| 2 | Acceptance word |
| 3 | Received word |
| 4 | Family |
| 5 | Status |
| 6 | Data low |
| 7 | Data high |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe for a decoded frame |
| frm_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| frm_id | input | 29 | Identifier; a standard frame uses bits 10:0 |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Mailbox index (bits 5:3) and register select (bits 2:0) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| drop_count | output | 16 | Count of unaccepted frames |

## Verification
The hardest case is an extended frame arriving while a lower-numbered standard catch-all mailbox is enabled and idle. Loose matching goes wrong exactly there. The bench sets up a standard catch-all in mailbox 5 below an extended catch-all in mailbox 6, then alternates standard and extended frames. It checks that each frame lands in the correct mailbox and that the acceptance word stays intact. A second hard case is a mailbox that is still ready when a new frame arrives. The bench sends two standard frames without a transfer command in between, then reads the first frame's data back to confirm it was kept.

// File: rtl/can_mbox_pkg.sv
// Shared constants, register field codes and the identifier-word packing
// used by the receive mailbox filter. Assumes a 29-bit identifier space.
package can_mbox_pkg;
    localparam int ID_W      = 29;
    localparam int WORD_W    = 30;
    localparam int FMT_BIT   = 29;
    localparam int STD_LSB   = 18;
    localparam int EN_BIT    = 0;
    localparam int XFER_BIT  = 8;
    localparam int RDY_BIT   = 23;
    localparam int LEN_LSB   = 16;

    typedef enum logic [2:0] {
        F_MODE   = 3'd0,
        F_MASK   = 3'd1,
        F_ACCID  = 3'd2,
        F_RXID   = 3'd3,
        F_FAMILY = 3'd4,
        F_STAT   = 3'd5,
        F_DLO    = 3'd6,
        F_DHI    = 3'd7
    } field_e;

    // Build the 30-bit identifier word from the frame format and identifier.
    function automatic logic [WORD_W-1:0] pack_id(input logic ext, input logic [ID_W-1:0] id);
        if (ext) return {1'b1, id};
        return {1'b0, id[10:0], {STD_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/can_mbox_match.sv
// Strict acceptance compare for one mailbox. It assumes the frame word was
// built with pack_id. The format bit must agree regardless of the mask.
module can_mbox_match
    import can_mbox_pkg::*;
(
    input  logic              en,
    input  logic              ready,
    input  logic [ID_W-1:0]   mask,
    input  logic [WORD_W-1:0] acc_id,
    input  logic [WORD_W-1:0] rx_word,
    output logic              hit
);
    logic fmt_eq;
    logic id_eq;

    // Compare the format bit unconditionally and the identifier bits under the mask.
    always_comb begin
        fmt_eq = (rx_word[FMT_BIT] == acc_id[FMT_BIT]);
        id_eq  = (((rx_word[ID_W-1:0] ^ acc_id[ID_W-1:0]) & mask) == '0);
        hit    = en && !ready && fmt_eq && id_eq;
    end
endmodule

// File: rtl/can_mbox_pick.sv
// Fixed-priority pick: the lowest-numbered hit wins. Purely combinational.
module can_mbox_pick #(
    parameter int NUM_MB = 8
) (
    input  logic [NUM_MB-1:0] hit,
    output logic [NUM_MB-1:0] grant,
    output logic              any
);
    // Scan from the top down so the lowest index overwrites the result last.
    always_comb begin
        grant = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (hit[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
        any = |hit;
    end

    // Guard the grant vector shape.
    always_comb begin
        a_r7_onehot: assert ($onehot0(grant));
        a_r7_subset: assert ((grant & ~hit) == '0);
    end
endmodule

// File: rtl/can_mbox_slot.sv
// One receive mailbox: configuration registers, captured frame storage and
// readback mux. It assumes that cap is asserted only when this slot matched.
module can_mbox_slot
    import can_mbox_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_field,
    input  logic [31:0]       wr_data,
    input  logic              cap,
    input  logic [WORD_W-1:0] cap_word,
    input  logic [3:0]        cap_len,
    input  logic [63:0]       cap_data,
    input  logic [TS_W-1:0]   cap_ts,
    input  logic [2:0]        rd_field,
    output logic              en,
    output logic              ready,
    output logic [ID_W-1:0]   mask,
    output logic [WORD_W-1:0] acc_id,
    output logic [31:0]       rd_data
);
    logic [WORD_W-1:0] rx_word;
    logic [ID_W-1:0]   family;
    logic [3:0]        len_q;
    logic [TS_W-1:0]   ts_q;
    logic [63:0]       data_q;
    logic              xfer;
    logic [1:0]        unused_wr;

    assign xfer      = wr_en && (wr_field == F_MODE) && wr_data[XFER_BIT];
    assign unused_wr = wr_data[31:30];

    // Configuration writes from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            mask   <= '0;
            acc_id <= '0;
        end else if (wr_en) begin
            case (wr_field)
                F_MODE:  en     <= wr_data[EN_BIT];
                F_MASK:  mask   <= wr_data[ID_W-1:0];
                F_ACCID: acc_id <= wr_data[WORD_W-1:0];
                default: ;
            endcase
        end
    end

    // Ready flag: set by a capture, cleared by the transfer command.
    always_ff @(posedge clk) begin
        if (!rst_n)    ready <= 1'b0;
        else if (cap)  ready <= 1'b1;
        else if (xfer) ready <= 1'b0;
    end

    // Store the captured frame fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
            family  <= '0;
            len_q   <= '0;
            ts_q    <= '0;
            data_q  <= '0;
        end else if (cap) begin
            rx_word <= cap_word;
            family  <= cap_word[ID_W-1:0] & mask;
            len_q   <= cap_len;
            ts_q    <= cap_ts;
            data_q  <= cap_data;
        end
    end

    // Readback mux for the selected register.
    always_comb begin
        rd_data = '0;
        case (rd_field)
            F_MODE:   rd_data[EN_BIT] = en;
            F_MASK:   rd_data[ID_W-1:0] = mask;
            F_ACCID:  rd_data[WORD_W-1:0] = acc_id;
            F_RXID:   rd_data[WORD_W-1:0] = rx_word;
            F_FAMILY: rd_data[ID_W-1:0] = family;
            F_STAT: begin
                rd_data[TS_W-1:0]          = ts_q;
                rd_data[LEN_LSB+3:LEN_LSB] = len_q;
                rd_data[RDY_BIT]           = ready;
            end
            F_DLO:    rd_data = data_q[31:0];
            default:  rd_data = data_q[63:32];
        endcase
    end

    // R11: a ready mailbox keeps its frame until a transfer command.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !xfer) |=> (ready && $stable(data_q) && $stable(rx_word)));

    // R10: without a register write, the configuration never moves.
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(acc_id) && $stable(mask) && $stable(en)));
endmodule

// File: rtl/can_rx_mbox_filter.sv
// Receive mailbox bank with strict acceptance filtering. It assumes frm_valid
// is a one-cycle strobe and that NUM_MB is a power of two. TS_W must be at most 16.
module can_rx_mbox_filter
    import can_mbox_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int TS_W   = 16,
    parameter int DROP_W = 16,
    localparam int MB_W   = $clog2(NUM_MB),
    localparam int ADDR_W = MB_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic [ID_W-1:0]   frm_id,
    input  logic [3:0]        frm_dlc,
    input  logic [63:0]       frm_data,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [DROP_W-1:0] drop_count
);
    logic [WORD_W-1:0] rx_word;
    logic [TS_W-1:0]   ts_ctr;
    logic [NUM_MB-1:0] en_v, rdy_v, hit_v, grant;
    logic              any_hit;
    logic [ID_W-1:0]   mask_v [NUM_MB];
    logic [WORD_W-1:0] acc_v  [NUM_MB];
    logic [31:0]       rd_v   [NUM_MB];

    assign rx_word = pack_id(frm_ext, frm_id);

    // Free-running timestamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_ctr <= '0;
        else        ts_ctr <= ts_ctr + 1'b1;
    end

    // Count frames that no mailbox accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                    drop_count <= '0;
        else if (frm_valid && !any_hit) drop_count <= drop_count + 1'b1;
    end

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        can_mbox_match u_match (
            .en      (en_v[i]),
            .ready   (rdy_v[i]),
            .mask    (mask_v[i]),
            .acc_id  (acc_v[i]),
            .rx_word (rx_word),
            .hit     (hit_v[i])
        );

        can_mbox_slot #(.TS_W(TS_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && (reg_addr[ADDR_W-1:3] == MB_W'(i))),
            .wr_field (reg_addr[2:0]),
            .wr_data  (reg_wdata),
            .cap      (frm_valid && grant[i]),
            .cap_word (rx_word),
            .cap_len  (frm_dlc),
            .cap_data (frm_data),
            .cap_ts   (ts_ctr),
            .rd_field (reg_addr[2:0]),
            .en       (en_v[i]),
            .ready    (rdy_v[i]),
            .mask     (mask_v[i]),
            .acc_id   (acc_v[i]),
            .rd_data  (rd_v[i])
        );

        // R4: a capture only happens when the formats agree.
        a_r4_fmt_strict: assert property (@(posedge clk) disable iff (!rst_n)
            (frm_valid && grant[i]) |-> (rx_word[FMT_BIT] == acc_v[i][FMT_BIT]));
        // R6: a disabled mailbox is never granted.
        a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            (frm_valid && grant[i]) |-> en_v[i]);
    end

    can_mbox_pick #(.NUM_MB(NUM_MB)) u_pick (
        .hit   (hit_v),
        .grant (grant),
        .any   (any_hit)
    );

    // Register readback selects the addressed mailbox.
    assign reg_rdata = rd_v[reg_addr[ADDR_W-1:3]];

    // R12: every unaccepted frame bumps the counter by exactly one.
    a_r12_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !any_hit) |=> (drop_count == $past(drop_count) + 1'b1));
    // R12: an accepted frame leaves the counter alone.
    a_r12_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && any_hit) |=> $stable(drop_count));
endmodule

// File: tb/can_rx_mbox_filter_bench.sv
module can_rx_mbox_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0, frm_ext = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] drop_count;
    logic [15:0] bcnt;
    logic [15:0] ts_exp;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_rx_mbox_filter u_can_rx_mbox_filter (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ext(frm_ext),
        .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .drop_count(drop_count));

    // Bench copy of the cycle count since reset (requirement R9).
    always @(posedge clk) begin
        if (!rst_n) bcnt <= '0;
        else        bcnt <= bcnt + 16'd1;
    end

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [3:0]  mb;
        logic [31:0] word;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{ext:1'b0, id:29'h123,      dlc:4'd8, mb:4'd5, word:32'h048C0000},
        '{ext:1'b1, id:29'h1576,     dlc:4'd8, mb:4'd6, word:32'h20001576},
        '{ext:1'b1, id:29'h15761234, dlc:4'd4, mb:4'd2, word:32'h35761234},
        '{ext:1'b0, id:29'h7FF,      dlc:4'd0, mb:4'd5, word:32'h1FFC0000},
        '{ext:1'b1, id:29'h15761235, dlc:4'd8, mb:4'd6, word:32'h35761235},
        '{ext:1'b1, id:29'h1FFFFFFF, dlc:4'd1, mb:4'd6, word:32'h3FFFFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int mb, input int f, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'(mb * 8 + f); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int mb, input int f, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(mb * 8 + f);
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic ext, input logic [28:0] id, input logic [3:0] dlc,
                        input logic [63:0] data);
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_dlc = dlc; frm_data = data;
        ts_exp = bcnt;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    function automatic logic [31:0] acc_cfg(input int mb);
        case (mb)
            2: return 32'h35761234;
            6: return 32'h20000000;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 drop_count", 32'(drop_count), 0);
        rd(5, 0, v); check("R1 mode", v, 0);
        rd(5, 5, v); check("R1 status", v, 0);
        rd(6, 2, v); check("R1 accid", v, 0);

        // Catch-all standard below catch-all extended, exact extended in mailbox 2.
        wr(5, 1, 32'h0);        wr(5, 2, 32'h0);        wr(5, 0, 32'h1);
        wr(6, 1, 32'h20000000); wr(6, 2, 32'h20000000); wr(6, 0, 32'h1);
        wr(2, 1, 32'h1FFFFFFF); wr(2, 2, 32'h35761234); wr(2, 0, 32'h1);

        // Table walk: R2 R3 R4 R5 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < 6; i++) begin
            vec_t t;
            t = VECS[i];
            send(t.ext, t.id, t.dlc, {56'hAAAAAAAAAAAAAA, 8'(i)});
            rd(int'(t.mb), 3, v); check(t.ext ? "R3 id word" : "R2 id word", v, t.word);
            rd(int'(t.mb), 6, v); check("R8 data low", v, {24'hAAAAAA, 8'(i)});
            rd(int'(t.mb), 7, v); check("R8 data high", v, 32'hAAAAAAAA);
            rd(int'(t.mb), 5, v);
            check("R9 status", v, 32'h00800000 | (32'(t.dlc) << 16) | 32'(ts_exp));
            rd(int'(t.mb), 2, v); check("R10 accid kept", v, acc_cfg(int'(t.mb)));
            rd(int'(t.mb), 0, v); check("R10 enable kept", v, 32'h1);
            for (int m = 2; m <= 6; m += 2) begin
                int mm;
                mm = (m == 4) ? 5 : m;
                if (mm != int'(t.mb)) begin
                    rd(mm, 5, v);
                    check(t.ext ? "R4 R7 other not ready" : "R5 R7 other not ready", 32'(v[23]), 0);
                end
            end
            wr(int'(t.mb), 0, 32'h101);
            rd(int'(t.mb), 5, v); check("R11 ready cleared", 32'(v[23]), 0);
            check("R12 no drop", 32'(drop_count), 0);
        end

        // R11: a ready mailbox ignores the next frame, which is dropped.
        send(1'b0, 29'h100, 4'd2, 64'h1111);
        send(1'b0, 29'h200, 4'd3, 64'h2222);
        rd(5, 3, v); check("R11 kept first id", v, 32'h04000000);
        rd(5, 6, v); check("R11 kept first data", v, 32'h1111);
        check("R12 drop after busy", 32'(drop_count), 1);
        wr(5, 0, 32'h101);

        // R6: disabled mailboxes never capture.
        wr(5, 0, 32'h0);
        send(1'b0, 29'h123, 4'd1, 64'h0);
        rd(5, 5, v); check("R6 disabled mb5", 32'(v[23]), 0);
        rd(0, 5, v); check("R6 disabled mb0", 32'(v[23]), 0);
        check("R12 drop unmatched", 32'(drop_count), 2);

        // R13: partial mask in mailbox 1.
        wr(1, 1, 32'h1FFF0000); wr(1, 2, 32'h35760000); wr(1, 0, 32'h1);
        send(1'b1, 29'h15769999, 4'd8, 64'h0);
        rd(1, 3, v); check("R13 masked hit id", v, 32'h35769999);
        rd(1, 4, v); check("R13 family", v, 32'h15760000);
        rd(6, 5, v); check("R7 lower wins", 32'(v[23]), 0);
        wr(1, 0, 32'h101);
        send(1'b1, 29'h14769999, 4'd8, 64'h0);
        rd(1, 5, v); check("R13 masked bit differs", 32'(v[23]), 0);
        rd(6, 5, v); check("R13 falls to mb6", 32'(v[23]), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule